// File: doc/BRIEF.md
# Monitor Channel Byte Receiver

This block is the receiving side of a byte-wide control channel that is carried inside a repeating frame. Once per frame an upstream deserialiser presents the sender's transmit-flag bit (active low, here called `mx_in`) and the channel byte, qualified by a one-cycle `frame_stb`. The block captures bytes, raises status for the host and returns an active-low acknowledge bit (`mr_out`) that the frame builder places in the outgoing frame. `mr_out` and the receive register change only on a frame strobe.

The host sees one receive register and two status flags: byte-received and end-of-message. It controls the exchange with a receive-enable bit and a flag-enable bit, and it reports that it has read the byte with a one-cycle read strobe. The read strobe also clears both flags. A byte counts as new only when `mx_in` goes from 1 to 0 between two frames. Each byte is acknowledged only after the host has read it. Two frames in a row with `mx_in` high end the message. If the host drops receive-enable in the middle of an exchange, the sender is told to abort.

The handshake is a seven-state machine. Its states and transitions are:
- **IDLE** (`mr_out`=1): goes to HOLD_FIRST when a byte is captured.
- **HOLD_FIRST** (`mr_out`=1): waits for the host to set receive-enable and read the byte, then goes to ACK_ON.
- **ACK_ON** (`mr_out`=0):
  - goes to HOLD_NEXT when a new byte arrives;
  - goes to END after two inactive frames;
  - goes to ABORT when receive-enable is cleared.
- **HOLD_NEXT** (`mr_out` stays 0): goes to GAP when the byte has been read, or to ABORT.
- **GAP** (`mr_out`=1 for one frame): goes to ACK_ON, or to ABORT.
- **END** (`mr_out`=0): goes to IDLE when receive-enable is cleared.
- **ABORT** (`mr_out`=1): goes to IDLE after `ABORT_FRAMES` further frames.

Top module: `mcr_receiver`

## Requirements
- R1: At any frame strobe where `rx_ctl` is 0, `mr_out` is 1 after that strobe.
- R2: A byte is captured into `rx_data` only at a frame strobe where `mx_in` is 0 and `mx_in` was 1 at the previous strobe, and only in IDLE or ACK_ON. While `mx_in` stays 0, nothing is captured again.
- R3: The first byte of a message is acknowledged by `mr_out`=0 at the first frame strobe where `rx_ctl`=1 and the byte has already been read.
- R4: Each later byte is acknowledged after the host has read it. At the next frame strobe `mr_out` goes to 1, and at the strobe after that it returns to 0.
- R5: In ACK_ON, a frame strobe with `mx_in`=1 that follows a strobe with `mx_in`=1 ends the message. `mr_out` then stays 0 until a strobe sees `rx_ctl`=0.
- R6: If `rx_ctl` is cleared in ACK_ON, HOLD_NEXT or GAP, `mr_out` is 1 for at least 1+`ABORT_FRAMES` strobes, and no byte is captured during the abort.
- R7: `drx_flag` is set on every capture in IDLE. A capture in ACK_ON sets `drx_flag` only when `irq_en`=1. End of message sets `eor_flag` only when `irq_en`=1.
- R8: While a captured byte is unread, `rx_data` is not overwritten and no acknowledge is sent.
- R9: Reset gives `mr_out`=1, `rx_data`=0, both flags 0 and the IDLE state.
- R10: `mr_out` and `rx_data` change only on a clock edge where `frame_stb` is 1.
- R11: A `rd_stb` pulse clears `drx_flag` and `eor_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_stb | input | 1 | One-cycle frame strobe; qualifies `mx_in` and `rx_byte_in` |
| mx_in | input | 1 | Sender transmit flag, 0 = byte valid |
| rx_byte_in | input | DATA_W | Channel byte of the current frame |
| rx_ctl | input | 1 | Host receive-enable; 0 forces `mr_out` inactive |
| irq_en | input | 1 | Host flag-enable for gated status |
| rd_stb | input | 1 | Host read strobe for `rx_data` |
| mr_out | output | 1 | Acknowledge bit to sender, 0 = active |
| rx_data | output | DATA_W | Receive register |
| drx_flag | output | 1 | Byte-received status |
| eor_flag | output | 1 | End-of-message status |

## Verification
Every result is registered on the clock edge that samples `frame_stb`, so `mr_out`, `rx_data` and the flags are due one cycle after the strobe. The flags clear one cycle after `rd_stb`. The bench drives each frame at a falling edge and drops the strobe at the next falling edge. It samples one further falling edge later, when exactly one rising edge has registered the frame. Between strobes the bench changes `mx_in` and the byte inputs and waits several cycles to show that nothing moves without a strobe.

// File: rtl/mcr_pkg.sv
`timescale 1ns/1ps
package mcr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD_FIRST,
        ST_ACK_ON,
        ST_HOLD_NEXT,
        ST_GAP,
        ST_END,
        ST_ABORT
    } mcr_state_e;

    function automatic logic mr_level(input mcr_state_e s);
        return !(s == ST_ACK_ON || s == ST_HOLD_NEXT || s == ST_END);
    endfunction
endpackage

// File: rtl/mcr_mx_track.sv
`timescale 1ns/1ps
module mcr_mx_track (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_stb,
    input  logic mx_in,
    output logic mx_fall,
    output logic mx_idle2
);
    logic mx_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         mx_prev_q <= 1'b1;
        else if (frame_stb) mx_prev_q <= mx_in;
    end

    assign mx_fall  = mx_prev_q & ~mx_in;
    assign mx_idle2 = mx_prev_q &  mx_in;
endmodule

// File: rtl/mcr_abort_timer.sv
`timescale 1ns/1ps
module mcr_abort_timer #(
    parameter int ABORT_FRAMES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_stb,
    input  logic run,
    output logic done
);
    localparam int CW = (ABORT_FRAMES > 1) ? $clog2(ABORT_FRAMES) : 1;
    localparam logic [CW-1:0] LAST = CW'(ABORT_FRAMES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (!run)               cnt_q <= '0;
        else if (frame_stb && !done) cnt_q <= cnt_q + 1'b1;
    end

    assign done = run && frame_stb && (cnt_q == LAST);
endmodule

// File: rtl/mcr_rx_store.sv
`timescale 1ns/1ps
module mcr_rx_store #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] dout,
    output logic              unread
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout   <= '0;
            unread <= 1'b0;
        end else if (load) begin
            dout   <= din;
            unread <= 1'b1;
        end else if (rd_stb) begin
            unread <= 1'b0;
        end
    end
endmodule

// File: rtl/mcr_receiver.sv
`timescale 1ns/1ps
module mcr_receiver #(
    parameter int DATA_W       = 8,
    parameter int ABORT_FRAMES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_stb,
    input  logic              mx_in,
    input  logic [DATA_W-1:0] rx_byte_in,
    input  logic              rx_ctl,
    input  logic              irq_en,
    input  logic              rd_stb,
    output logic              mr_out,
    output logic [DATA_W-1:0] rx_data,
    output logic              drx_flag,
    output logic              eor_flag
);
    import mcr_pkg::*;

    mcr_state_e state_q, state_d;
    logic mx_fall, mx_idle2, abort_done, unread;
    logic load, set_drx, set_eor;

    mcr_mx_track u_mx (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .mx_in(mx_in),
        .mx_fall(mx_fall), .mx_idle2(mx_idle2)
    );

    mcr_abort_timer #(.ABORT_FRAMES(ABORT_FRAMES)) u_abort (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb),
        .run(state_q == ST_ABORT), .done(abort_done)
    );

    mcr_rx_store #(.DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n), .load(load), .din(rx_byte_in),
        .rd_stb(rd_stb), .dout(rx_data), .unread(unread)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        set_drx = 1'b0;
        set_eor = 1'b0;
        if (frame_stb) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (mx_fall && !unread) begin
                        load    = 1'b1;
                        set_drx = 1'b1;
                        state_d = ST_HOLD_FIRST;
                    end
                end
                ST_HOLD_FIRST: begin
                    if (rx_ctl && !unread) state_d = ST_ACK_ON;
                end
                ST_ACK_ON: begin
                    if (!rx_ctl) begin
                        state_d = ST_ABORT;
                    end else if (mx_fall) begin
                        load    = 1'b1;
                        set_drx = irq_en;
                        state_d = ST_HOLD_NEXT;
                    end else if (mx_idle2) begin
                        set_eor = irq_en;
                        state_d = ST_END;
                    end
                end
                ST_HOLD_NEXT: begin
                    if (!rx_ctl)      state_d = ST_ABORT;
                    else if (!unread) state_d = ST_GAP;
                end
                ST_GAP: begin
                    state_d = rx_ctl ? ST_ACK_ON : ST_ABORT;
                end
                ST_END: begin
                    if (!rx_ctl) state_d = ST_IDLE;
                end
                ST_ABORT: begin
                    if (abort_done) state_d = ST_IDLE;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs: acknowledge bit and status flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mr_out   <= 1'b1;
            drx_flag <= 1'b0;
            eor_flag <= 1'b0;
        end else begin
            if (frame_stb) mr_out <= mr_level(state_d);
            if (set_drx)     drx_flag <= 1'b1;
            else if (rd_stb) drx_flag <= 1'b0;
            if (set_eor)     eor_flag <= 1'b1;
            else if (rd_stb) eor_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/mcr_receiver_chk.sv
`timescale 1ns/1ps
module mcr_receiver_chk #(
    parameter int DATA_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 frame_stb,
    input logic                 rx_ctl,
    input logic                 irq_en,
    input logic                 mr_out,
    input logic [DATA_W-1:0]    rx_data,
    input logic                 eor_flag,
    input logic                 unread,
    input mcr_pkg::mcr_state_e  state_q
);
    import mcr_pkg::*;

    assert_force_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb && !rx_ctl |=> mr_out);

    assert_abort_inactive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_ABORT |-> mr_out);

    assert_eor_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eor_flag) |-> $past(irq_en));

    assert_no_overwrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb && unread |=> $stable(rx_data));

    assert_no_early_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb && unread && state_q == ST_HOLD_FIRST |=> mr_out);

    assert_mr_frame_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> $stable(mr_out));

    assert_data_frame_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> $stable(rx_data));
endmodule

bind mcr_receiver mcr_receiver_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .rx_ctl(rx_ctl),
    .irq_en(irq_en), .mr_out(mr_out), .rx_data(rx_data),
    .eor_flag(eor_flag), .unread(unread), .state_q(state_q)
);

// File: tb/mcr_receiver_tb.sv
`timescale 1ns/1ps
module mcr_receiver_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_stb = 1'b0;
    logic       mx_in = 1'b1;
    logic [7:0] rx_byte_in = '0;
    logic       rx_ctl = 1'b0;
    logic       irq_en = 1'b0;
    logic       rd_stb = 1'b0;
    logic       mr_out;
    logic [7:0] rx_data;
    logic       drx_flag;
    logic       eor_flag;

    int  tests = 0;
    int  fails = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    mcr_receiver #(.DATA_W(8), .ABORT_FRAMES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .mx_in(mx_in),
        .rx_byte_in(rx_byte_in), .rx_ctl(rx_ctl), .irq_en(irq_en),
        .rd_stb(rd_stb), .mr_out(mr_out), .rx_data(rx_data),
        .drx_flag(drx_flag), .eor_flag(eor_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic frame(input logic mx, input logic [7:0] b);
        @(negedge clk);
        frame_stb  = 1'b1;
        mx_in      = mx;
        rx_byte_in = b;
        @(negedge clk);
        frame_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_read(output logic [7:0] d);
        @(negedge clk);
        d = rx_data;
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic run_msg(input int len, input logic en);
        logic [7:0] b;
        logic [7:0] got;
        irq_en = en;
        rx_ctl = 1'b0;
        frame(1'b1, 8'h00);
        check("R1 idle mr", mr_out, 1);
        b = 8'((len * 37) + (en ? 101 : 3));
        frame(1'b0, b);
        check("R2 first capture", rx_data, b);
        check("R7 first drx", drx_flag, 1);
        check("R1 mr with ctl low", mr_out, 1);
        // R10: inputs move without a strobe
        mx_in = 1'b1; rx_byte_in = ~b;
        repeat (3) @(negedge clk);
        check("R10 data still", rx_data, b);
        check("R10 mr still", mr_out, 1);
        frame(1'b0, ~b);
        check("R2 steady active no recapture", rx_data, b);
        rx_ctl = 1'b1;
        frame(1'b0, ~b);
        check("R8 no ack before read", mr_out, 1);
        do_read(got);
        check("R2 read value", got, b);
        check("R11 drx cleared", drx_flag, 0);
        frame(1'b0, ~b);
        check("R3 first ack", mr_out, 0);
        for (int k = 1; k < len; k++) begin
            b = 8'((len * 37) + (k * 11) + (en ? 101 : 3));
            frame(1'b1, 8'h00);
            check("R4 mr held active", mr_out, 0);
            frame(1'b0, b);
            check("R2 later capture", rx_data, b);
            check("R7 later drx gated", drx_flag, en);
            check("R4 mr during hold", mr_out, 0);
            frame(1'b0, b ^ 8'hFF);
            check("R8 no overwrite", rx_data, b);
            check("R8 no ack while unread", mr_out, 0);
            do_read(got);
            check("R2 later read", got, b);
            frame(1'b0, 8'h00);
            check("R4 gap inactive", mr_out, 1);
            frame(1'b0, 8'h00);
            check("R4 ack active again", mr_out, 0);
        end
        frame(1'b1, 8'h00);
        check("R5 one inactive frame no eor", eor_flag, 0);
        frame(1'b1, 8'h00);
        check("R5 eor gated by enable (R7)", eor_flag, en);
        check("R5 mr held after end", mr_out, 0);
        frame(1'b1, 8'h00);
        check("R5 mr held until ctl low", mr_out, 0);
        rx_ctl = 1'b0;
        frame(1'b1, 8'h00);
        check("R1 release after end", mr_out, 1);
        do_read(got);
        check("R11 eor cleared", eor_flag, 0);
    endtask

    initial begin
        logic [7:0] got;
        repeat (3) @(negedge clk);
        check("R9 reset mr", mr_out, 1);
        check("R9 reset data", rx_data, 0);
        check("R9 reset drx", drx_flag, 0);
        check("R9 reset eor", eor_flag, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int en = 0; en < 2; en++)
            for (int len = 1; len <= 4; len++)
                run_msg(len, 1'(en));

        // Abort during ACK_ON
        irq_en = 1'b1;
        rx_ctl = 1'b0;
        frame(1'b1, 8'h00);
        frame(1'b0, 8'hC3);
        rx_ctl = 1'b1;
        do_read(got);
        frame(1'b0, 8'h00);
        check("R3 ack before abort", mr_out, 0);
        rx_ctl = 1'b0;
        frame(1'b1, 8'h00);
        check("R6 abort mr inactive", mr_out, 1);
        rx_ctl = 1'b1;
        frame(1'b0, 8'hEE);
        check("R6 abort holds mr", mr_out, 1);
        check("R6 no capture during abort", rx_data, 8'hC3);
        frame(1'b1, 8'h00);
        check("R6 abort second frame", mr_out, 1);
        frame(1'b0, 8'h5A);
        check("R6 capture after abort", rx_data, 8'h5A);
        check("R6 mr after abort capture", mr_out, 1);
        do_read(got);
        frame(1'b0, 8'h00);
        check("R3 ack after abort", mr_out, 0);
        frame(1'b1, 8'h00);
        frame(1'b1, 8'h00);
        check("R5 eor after abort", eor_flag, 1);
        rx_ctl = 1'b0;
        frame(1'b1, 8'h00);
        check("R1 final release", mr_out, 1);
        do_read(got);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule